// File: doc/BRIEF.md
# Soft-Start and Thermal Fault Sequencer

This block controls how a step-down converter starts and stops. It takes an enable level, a temperature reading coded in whole degrees Celsius and a two-bit voltage select. It drives a millivolt reference code for the regulation loop, a run level that lets the switching controller operate, and a thermal fault flag. The reference DAC and the temperature sensor sit outside the block. Both are represented here by digital codes.

When the block is enabled, the reference starts at zero and climbs in fixed steps, paced by a clock divider, until it reaches the selected target. With default parameters a 1.8 V target takes about 1.5 ms at 250 MHz. Once the target is reached, a new select value does not make the reference jump. The reference moves toward the new value at the same paced rate, either up or down. An overheat trip stops everything at once. The block restarts with a fresh soft-start only after the temperature has fallen below a lower recovery point.

Top module: `softstart_seq`

## Requirements
- R1: While `enable_i` is low, `ref_code_o` is 0 and `run_o` is 0. This holds from the first clock edge after `enable_i` is sampled low. Select changes in that time leave `ref_code_o` at 0.
- R2: When `enable_i` is sampled high and no fault is present, `run_o` is 1 from the next edge, and the ramp starts with `ref_code_o` at 0.
- R3: While running, `ref_code_o` changes only on divider ticks. Exactly one tick falls in every `TICK_DIV` consecutive cycles, and the first tick lands `TICK_DIV` edges after `run_o` rises. Each tick moves the code by `STEP_MV` toward the target. The last step is clipped so the code lands exactly on the target.
- R4: The select `vsel_i` maps to targets as follows: 2'b00 gives 1050 mV, 2'b10 gives 1350 mV, 2'b11 gives 1570 mV and 2'b01 gives 1800 mV. Bit 0 idles low and bit 1 idles high, so the idle code 2'b10 gives 1350 mV. The code never exceeds 1800 mV.
- R5: After the target has been reached, a select change moves the code one `STEP_MV` per tick toward the new target, up or down, and never more per tick.
- R6: A temperature code above 160 (strictly) sets `fault_o` and clears `run_o` and `ref_code_o` one edge after it is sampled. A code of 160 does not trip.
- R7: `fault_o` stays set while the temperature code is 135 or more. It clears one edge after a code below 135 is sampled. If the block is enabled, the ramp restarts from 0 at that same edge.
- R8: The thermal flag is tracked while the block is disabled. An enable during a fault keeps `run_o` low until the fault clears.
- R9: A select change during the ramp sends the ramp toward the new target. If the code is already above the new target, it steps down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enable level |
| vsel_i | input | 2 | Target voltage select |
| temp_i | input | TEMP_W | Die temperature in degrees Celsius, unsigned |
| ref_code_o | output | REF_W | Reference code in millivolts |
| run_o | output | 1 | Switching controller allowed to operate |
| fault_o | output | 1 | Thermal fault present |

## Verification
Damage to the tick counter, the reference register or the hysteresis flag shows up at the ports within a few cycles. A wrong divider phase or a wrong step size moves `ref_code_o` off the expected value within one `TICK_DIV` window. Every window holds exactly one tick, so the expected code after a whole number of windows does not depend on the counter phase. A lost hysteresis flag shows as `run_o` returning while the temperature is still inside the 135..160 band, one edge after the band is entered. A reference register that misses its clear shows as a nonzero code at the first edge after a disable or a trip.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

   typedef enum logic [1:0] {
      SEQ_OFF    = 2'd0,
      SEQ_ACTIVE = 2'd1,
      SEQ_HOT    = 2'd2
   } seq_state_t;

   localparam int unsigned TGT_MV_00 = 1050;
   localparam int unsigned TGT_MV_10 = 1350;
   localparam int unsigned TGT_MV_11 = 1570;
   localparam int unsigned TGT_MV_01 = 1800;
   localparam int unsigned TGT_MV_MAX = 1800;

   // bit 0 idles low, bit 1 idles high; the code order is not binary
   function automatic int unsigned sel_to_mv(input logic [1:0] sel);
      case (sel)
         2'b00:   return TGT_MV_00;
         2'b10:   return TGT_MV_10;
         2'b11:   return TGT_MV_11;
         default: return TGT_MV_01;
      endcase
   endfunction

endpackage

// File: rtl/thermal_mon.sv
module thermal_mon #(
   parameter int unsigned TEMP_W   = 8,
   parameter int unsigned TRIP_HOT = 160,
   parameter int unsigned TRIP_OK  = 135
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_i,
   output logic              trip_now_o,
   output logic              hot_q_o
);
   localparam logic [TEMP_W-1:0] HOT_C = TEMP_W'(TRIP_HOT);
   localparam logic [TEMP_W-1:0] OK_C  = TEMP_W'(TRIP_OK);

   generate
      if (TRIP_OK >= TRIP_HOT) begin : g_bad_band
         $error("thermal_mon: recovery point must lie below trip point");
      end
      if (TRIP_HOT >= (1 << TEMP_W)) begin : g_bad_width
         $error("thermal_mon: trip point does not fit TEMP_W");
      end
   endgenerate

   logic hot_q;

   always_comb begin
      trip_now_o = (temp_i > HOT_C) || (hot_q && (temp_i >= OK_C));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hot_q <= 1'b0;
      else        hot_q <= trip_now_o;
   end

   assign hot_q_o = hot_q;

   assert_trip_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hot_q) |-> ($past(temp_i) > HOT_C));

   assert_hold_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_q && (temp_i >= OK_C)) |=> hot_q);

endmodule

// File: rtl/tick_div.sv
module tick_div #(
   parameter int unsigned TICK_DIV = 208
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   output logic tick_o
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("tick_div: TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_every
         assign tick_o = active_i;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(TICK_DIV);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!active_i)     cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end

         assign tick_o = active_i && (cnt_q == LAST);

         assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
      end
   endgenerate

endmodule

// File: rtl/ref_slew.sv
module ref_slew #(
   parameter int unsigned REF_W   = 11,
   parameter int unsigned STEP_MV = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic [REF_W-1:0] target_i,
   output logic [REF_W-1:0] ref_o
);
   localparam logic [REF_W-1:0] STEP_C = REF_W'(STEP_MV);

   generate
      if (STEP_MV < 1 || STEP_MV >= (1 << REF_W)) begin : g_bad_step
         $error("ref_slew: STEP_MV out of range");
      end
   endgenerate

   logic [REF_W-1:0] ref_q;
   logic [REF_W-1:0] ref_d;
   logic [REF_W-1:0] gap;

   always_comb begin
      gap   = (ref_q < target_i) ? (target_i - ref_q) : (ref_q - target_i);
      ref_d = ref_q;
      if (ref_q < target_i)
         ref_d = (gap > STEP_C) ? (ref_q + STEP_C) : target_i;
      else if (ref_q > target_i)
         ref_d = (gap > STEP_C) ? (ref_q - STEP_C) : target_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ref_q <= '0;
      else if (clear_i) ref_q <= '0;
      else if (tick_i)  ref_q <= ref_d;
   end

   assign ref_o = ref_q;

   function automatic logic [REF_W-1:0] absdiff(input logic [REF_W-1:0] a,
                                               input logic [REF_W-1:0] b);
      return (a > b) ? (a - b) : (b - a);
   endfunction

   assert_slew_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (absdiff(ref_q, $past(ref_q)) <= STEP_C));

   assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !tick_i) |=> $stable(ref_q));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
   import vseq_pkg::*;
#(
   parameter int unsigned REF_W    = 11,
   parameter int unsigned TEMP_W   = 8,
   parameter int unsigned TICK_DIV = 208,
   parameter int unsigned STEP_MV  = 1,
   parameter int unsigned TRIP_HOT = 160,
   parameter int unsigned TRIP_OK  = 135
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic [1:0]        vsel_i,
   input  logic [TEMP_W-1:0] temp_i,
   output logic [REF_W-1:0]  ref_code_o,
   output logic              run_o,
   output logic              fault_o
);
   localparam logic [REF_W-1:0] MAX_C = REF_W'(TGT_MV_MAX);

   generate
      if (TGT_MV_MAX >= (1 << REF_W)) begin : g_bad_ref
         $error("softstart_seq: REF_W too narrow for the largest target");
      end
   endgenerate

   seq_state_t       state_q, state_d;
   logic             trip_now;
   logic             hot_q;
   logic             tick;
   logic [REF_W-1:0] target;

   thermal_mon #(
      .TEMP_W  (TEMP_W),
      .TRIP_HOT(TRIP_HOT),
      .TRIP_OK (TRIP_OK)
   ) u_therm (
      .clk       (clk),
      .rst_n     (rst_n),
      .temp_i    (temp_i),
      .trip_now_o(trip_now),
      .hot_q_o   (hot_q)
   );

   always_comb begin
      if (trip_now)      state_d = SEQ_HOT;
      else if (!enable_i) state_d = SEQ_OFF;
      else               state_d = SEQ_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_OFF;
      else        state_q <= state_d;
   end

   tick_div #(
      .TICK_DIV(TICK_DIV)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(state_q == SEQ_ACTIVE),
      .tick_o  (tick)
   );

   assign target = REF_W'(sel_to_mv(vsel_i));

   ref_slew #(
      .REF_W  (REF_W),
      .STEP_MV(STEP_MV)
   ) u_slew (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (state_d != SEQ_ACTIVE),
      .tick_i  (tick),
      .target_i(target),
      .ref_o   (ref_code_o)
   );

   assign run_o   = (state_q == SEQ_ACTIVE);
   assign fault_o = hot_q;

   assert_run_off_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !run_o);

   assert_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!run_o && (ref_code_o == '0)));

   assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_code_o <= MAX_C);

   assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> (ref_code_o == '0));

endmodule

// File: tb/softstart_seq_test.sv
module softstart_seq_test;
   localparam int DIV  = 3;
   localparam int STEP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable_i = 1'b0;
   logic [1:0]  vsel_i = 2'b10;
   logic [7:0]  temp_i = 8'd25;
   logic [10:0] ref_code_o;
   logic        run_o;
   logic        fault_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   softstart_seq #(
      .REF_W(11), .TEMP_W(8), .TICK_DIV(DIV), .STEP_MV(STEP),
      .TRIP_HOT(160), .TRIP_OK(135)
   ) uut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .vsel_i(vsel_i),
      .temp_i(temp_i), .ref_code_o(ref_code_o), .run_o(run_o), .fault_o(fault_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   task automatic t_reset();
      chk("R1", "ref after reset", ref_code_o, 0);
      chk("R1", "run after reset", run_o, 0);
      chk("R6", "fault after reset", fault_o, 0);
   endtask

   task automatic t_off_ignores_sel();
      for (int s = 0; s < 4; s++) begin
         vsel_i = 2'(s);
         step(DIV + 1);
         chk("R1", "ref while disabled", ref_code_o, 0);
      end
      vsel_i = 2'b10;
   endtask

   // full soft-start from off to the selected target
   task automatic t_ramp(input logic [1:0] sel, input int tgt);
      int n;
      n = ceil_div(tgt, STEP);
      vsel_i = sel;
      enable_i = 1'b1;
      step(1);
      chk("R2", "run at start", run_o, 1);
      chk("R2", "ref at start", ref_code_o, 0);
      step(DIV - 1);
      chk("R3", "ref before first tick", ref_code_o, 0);
      step(1);
      chk("R3", "ref after first tick", ref_code_o, STEP);
      step(DIV * (n - 2));
      chk("R3", "ref one tick short", ref_code_o, (n - 1) * STEP);
      step(DIV);
      chk("R4", "ref lands on target", ref_code_o, tgt);
      step(DIV * 3);
      chk("R4", "ref holds target", ref_code_o, tgt);
   endtask

   task automatic t_retarget(input string req, input logic [1:0] sel, input int from, input int to);
      int d;
      int n;
      int first;
      d = (to > from) ? to - from : from - to;
      n = ceil_div(d, STEP);
      if (d <= STEP) first = to;
      else first = (to > from) ? from + STEP : from - STEP;
      vsel_i = sel;
      step(DIV);
      chk(req, "ref one window after change", ref_code_o, first);
      if (n > 1) step(DIV * (n - 1));
      chk(req, "ref reaches new target", ref_code_o, to);
      step(DIV * 2);
      chk(req, "ref stays at new target", ref_code_o, to);
   endtask

   task automatic t_disable();
      enable_i = 1'b0;
      step(1);
      chk("R1", "run after disable", run_o, 0);
      chk("R1", "ref after disable", ref_code_o, 0);
   endtask

   task automatic t_ramp_retarget();
      vsel_i = 2'b01;
      enable_i = 1'b1;
      step(1);
      step(DIV * 160);
      chk("R9", "ref mid ramp", ref_code_o, 1280);
      t_retarget("R9", 2'b00, 1280, 1050);
   endtask

   task automatic t_thermal();
      temp_i = 8'd160;
      step(1);
      chk("R6", "fault at 160", fault_o, 0);
      chk("R6", "run at 160", run_o, 1);
      chk("R6", "ref at 160", ref_code_o, 1050);
      temp_i = 8'd161;
      step(1);
      chk("R6", "fault at 161", fault_o, 1);
      chk("R6", "run at 161", run_o, 0);
      chk("R6", "ref at 161", ref_code_o, 0);
      temp_i = 8'd140;
      step(5);
      chk("R7", "fault inside band", fault_o, 1);
      chk("R7", "run inside band", run_o, 0);
      temp_i = 8'd135;
      step(2);
      chk("R7", "fault at 135", fault_o, 1);
      chk("R7", "ref at 135", ref_code_o, 0);
      temp_i = 8'd134;
      step(1);
      chk("R7", "fault at 134", fault_o, 0);
      chk("R7", "run restart", run_o, 1);
      chk("R7", "ref restart at zero", ref_code_o, 0);
      step(DIV);
      chk("R7", "ref first restart step", ref_code_o, STEP);
      temp_i = 8'd25;
   endtask

   task automatic t_fault_disabled();
      enable_i = 1'b0;
      step(1);
      temp_i = 8'd200;
      step(1);
      chk("R8", "fault while disabled", fault_o, 1);
      enable_i = 1'b1;
      step(4);
      chk("R8", "run held by fault", run_o, 0);
      chk("R8", "ref held by fault", ref_code_o, 0);
      temp_i = 8'd100;
      step(1);
      chk("R8", "fault cleared", fault_o, 0);
      chk("R8", "run after clear", run_o, 1);
      chk("R8", "ref after clear", ref_code_o, 0);
      enable_i = 1'b0;
      temp_i = 8'd25;
      step(1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_off_ignores_sel();
      t_ramp(2'b10, 1350);
      t_retarget("R5", 2'b11, 1350, 1570);
      t_retarget("R5", 2'b01, 1570, 1800);
      t_retarget("R5", 2'b00, 1800, 1050);
      t_disable();
      t_ramp(2'b01, 1800);
      t_disable();
      t_ramp(2'b00, 1050);
      t_thermal();
      t_disable();
      t_ramp(2'b11, 1570);
      t_disable();
      t_ramp_retarget();
      t_disable();
      t_fault_disabled();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule